// File: doc/BRIEF.md
# Character Glyph Pixel Serializer

This block turns one character of a text display into the dots of one scan line. It receives a 7-bit ASCII value and the index of the scan line being drawn within the character cell. It maps the ASCII value onto a 64-entry glyph set, and it reads a 5-dot row pattern from a computed glyph table addressed by the 6-bit glyph code and the 3-bit row. It pads that pattern with three blank dots and shifts the result out as one pixel per pixel clock, most significant dot first.

A display timing generator feeds the block. It pulses `load_stb` once per character cell, every eight pixel clocks, and presents the character together with its scan row on the same cycle. When the character cell holds the cursor, `cursor_here` is raised. While `blink_en` is set, the block then flips the top bit of the glyph code during the high half of an internal blink square wave, so a blank cell at the cursor alternates between a space and an '@'. The blink wave comes from a free-running divider of the pixel clock. With the default divider the wave runs at about 2 Hz for a 7.16 MHz pixel clock.

The shifter is a two-state machine. `SER_IDLE` drives a dark pixel. `SER_SHIFT` emits the loaded pattern. The transition *start* (IDLE to SHIFT) fires on `load_stb`. The transition *reload* (SHIFT to SHIFT) fires on `load_stb` at any dot and restarts the pattern. The transition *drain* (SHIFT to IDLE) fires after the eighth dot when no load arrives.

Top module: `glyph_pixel_serializer`

## Requirements
- R1: While `rst_n` is low and after its release until the first load, `pixel_out` is 0.
- R2: `load_stb` is sampled at a rising clock edge. From the cycle after that edge, `pixel_out` shows glyph dots 4, 3, 2, 1, 0 on five successive cycles, followed by three 0 pixels.
- R3: The glyph code is built as follows. Bit 5 is the inverse of ASCII bit 6, and bits 4..0 are ASCII bits 4..0. ASCII bit 5 is dropped. As a result, 0x40–0x7F map to codes 0x00–0x1F, 0x20–0x3F keep their value, and 0x00–0x1F map to 0x20–0x3F.
- R4: Scan row 7 is blank for every code.
- R5: Code 0x20 (space) is blank on every row. Code 0x00 ('@') has rows 0..6 equal to 0x0E, 0x11, 0x17, 0x15, 0x17, 0x10, 0x0F, where bit 4 is the leftmost dot.
- R6: Any other code c has row r (0..6) equal to (c + 7·r) mod 32.
- R7: When `cursor_here`, `blink_en` and the blink phase are all 1 at the load edge, bit 5 of the glyph code is inverted before the table lookup.
- R8: The blink phase is 0 after reset and inverts once every `BLINK_HALF` clock cycles counted from reset release.
- R9: When `blink_en` is 0, `cursor_here` has no effect on the pixels.
- R10: If no new load arrives, the output stays 0 from the ninth cycle after a load onward, and the machine returns to `SER_IDLE`.
- R11: A load arriving during a pattern discards the rest of the old pattern and starts the new one in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ascii_in | input | 7 | ASCII value of the character cell |
| scan_row | input | 3 | Scan line within the character cell |
| cursor_here | input | 1 | The cell being loaded is the cursor position |
| blink_en | input | 1 | Allows the cursor to blink |
| load_stb | input | 1 | Loads a new dot pattern into the shifter |
| pixel_out | output | 1 | Serial pixel |

## Verification
The bench sweeps all 128 ASCII values across all eight scan rows. A fold that kept bit 5 instead of inverting bit 6 would put wrong glyphs on lowercase and control codes. An off-by-one in the dot order would shift or mirror every pattern. A table that lit row 7 would merge vertically adjacent characters.

Cursor cells are loaded back to back across several blink half-periods. This catches a phase that starts high, toggles at the wrong count, or flips the code while blinking is disabled. A reload in the middle of a pattern catches a shifter that finishes the old dots first. An idle stretch catches a shifter that recirculates its contents instead of going dark.

// File: rtl/glyph_ser_pkg.sv
package glyph_ser_pkg;
    localparam int ASCII_W = 7;
    localparam int CODE_W  = 6;
    localparam int ROW_W   = 3;
    localparam int DOT_W   = 5;
    localparam int SHIFT_W = 8;

    typedef enum logic [0:0] {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;

    localparam logic [CODE_W-1:0] CODE_AT    = 6'h00;
    localparam logic [CODE_W-1:0] CODE_SPACE = 6'h20;
endpackage

// File: rtl/glyph_code_fold.sv
module glyph_code_fold #(
    parameter int ASCII_W = glyph_ser_pkg::ASCII_W,
    parameter int CODE_W  = glyph_ser_pkg::CODE_W
) (
    input  logic [ASCII_W-1:0] ascii,
    input  logic               flip_top,
    output logic [CODE_W-1:0]  code
);
    localparam int LOW_W = CODE_W - 1;

    always_comb begin
        code[LOW_W-1:0] = ascii[LOW_W-1:0];
        code[CODE_W-1]  = ~ascii[ASCII_W-1] ^ flip_top;
    end
endmodule

// File: rtl/glyph_rom.sv
module glyph_rom #(
    parameter int CODE_W    = glyph_ser_pkg::CODE_W,
    parameter int ROW_W     = glyph_ser_pkg::ROW_W,
    parameter int DOT_W     = glyph_ser_pkg::DOT_W,
    parameter int BLANK_ROW = 7
) (
    input  logic [CODE_W-1:0] code,
    input  logic [ROW_W-1:0]  row,
    output logic [DOT_W-1:0]  dots
);
    import glyph_ser_pkg::*;

    localparam int ROW_STEP = 7;
    localparam int DOT_MOD  = 1 << DOT_W;

    int unsigned synth_val;

    always_comb begin
        synth_val = (int'(code) + ROW_STEP * int'(row)) % DOT_MOD;
        if (row == ROW_W'(BLANK_ROW)) begin
            dots = '0;
        end else if (code == CODE_SPACE) begin
            dots = '0;
        end else if (code == CODE_AT) begin
            unique case (row)
                3'd0:    dots = 5'h0E;
                3'd1:    dots = 5'h11;
                3'd2:    dots = 5'h17;
                3'd3:    dots = 5'h15;
                3'd4:    dots = 5'h17;
                3'd5:    dots = 5'h10;
                3'd6:    dots = 5'h0F;
                default: dots = '0;
            endcase
        end else begin
            dots = synth_val[DOT_W-1:0];
        end
    end
endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
    parameter int BLINK_HALF = 1789772
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase,
    output logic wrap
);
    localparam int CNT_W = (BLINK_HALF > 2) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter #(
    parameter int DOT_W   = glyph_ser_pkg::DOT_W,
    parameter int SHIFT_W = glyph_ser_pkg::SHIFT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [DOT_W-1:0]           dots,
    output logic                       pixel,
    output logic                       busy,
    output logic [$clog2(SHIFT_W)-1:0] dot_idx
);
    import glyph_ser_pkg::*;

    localparam int IDX_W = $clog2(SHIFT_W);
    localparam int PAD_W = SHIFT_W - DOT_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SHIFT_W - 1);

    ser_state_e         state, state_nx;
    logic [SHIFT_W-1:0] shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= state_nx;
    end

    // transitions: start, reload, drain
    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE:  if (load) state_nx = SER_SHIFT;
            SER_SHIFT: if (!load && dot_idx == LAST) state_nx = SER_IDLE;
            default:   state_nx = SER_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            dot_idx <= '0;
        end else if (load) begin
            shreg   <= {dots, {PAD_W{1'b0}}};
            dot_idx <= '0;
        end else if (state == SER_SHIFT) begin
            shreg   <= shreg << 1;
            dot_idx <= (dot_idx == LAST) ? '0 : dot_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            SER_SHIFT: pixel = shreg[SHIFT_W-1];
            default:   pixel = 1'b0;
        endcase
        busy = (state == SER_SHIFT);
    end
endmodule

// File: rtl/glyph_pixel_serializer.sv
module glyph_pixel_serializer #(
    parameter int BLINK_HALF = 1789772,
    parameter int BLANK_ROW  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] ascii_in,
    input  logic [2:0] scan_row,
    input  logic       cursor_here,
    input  logic       blink_en,
    input  logic       load_stb,
    output logic       pixel_out
);
    import glyph_ser_pkg::*;

    localparam int IDX_W = $clog2(SHIFT_W);

    logic              blink_phase, blink_wrap;
    logic              flip;
    logic [CODE_W-1:0] code;
    logic [DOT_W-1:0]  dots;
    logic              ser_busy;
    logic [IDX_W-1:0]  ser_idx;

    blink_divider #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(blink_phase), .wrap(blink_wrap)
    );

    assign flip = cursor_here & blink_en & blink_phase;

    glyph_code_fold #(.ASCII_W(ASCII_W), .CODE_W(CODE_W)) u_fold (
        .ascii(ascii_in), .flip_top(flip), .code(code)
    );

    glyph_rom #(.CODE_W(CODE_W), .ROW_W(ROW_W), .DOT_W(DOT_W),
                .BLANK_ROW(BLANK_ROW)) u_rom (
        .code(code), .row(scan_row), .dots(dots)
    );

    pixel_shifter #(.DOT_W(DOT_W), .SHIFT_W(SHIFT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .dots(dots),
        .pixel(pixel_out), .busy(ser_busy), .dot_idx(ser_idx)
    );
endmodule

// File: rtl/glyph_ser_checker.sv
module glyph_ser_checker #(
    parameter int BLANK_ROW = 7,
    parameter int DOT_W     = 5,
    parameter int SHIFT_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [6:0]                 ascii_in,
    input logic [2:0]                 scan_row,
    input logic                       cursor_here,
    input logic                       blink_en,
    input logic                       load_stb,
    input logic                       pixel_out,
    input logic                       busy,
    input logic [$clog2(SHIFT_W)-1:0] dot_idx,
    input logic                       blink_phase,
    input logic                       blink_wrap
);
    localparam int IDX_W = $clog2(SHIFT_W);

    assert_idle_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pixel_out);

    assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && dot_idx == IDX_W'(SHIFT_W - 1) && !load_stb |=> !busy);

    assert_pad_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && dot_idx >= IDX_W'(DOT_W) |-> !pixel_out);

    assert_blank_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && scan_row == 3'(BLANK_ROW) |=> !pixel_out);

    assert_space_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && ascii_in == 7'h20 && !(cursor_here && blink_en) |=> !pixel_out);

    assert_phase_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blink_wrap |=> blink_phase != $past(blink_phase));

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_wrap |=> $stable(blink_phase));

    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> busy && dot_idx == '0);
endmodule

bind glyph_pixel_serializer glyph_ser_checker #(
    .BLANK_ROW(BLANK_ROW), .DOT_W(glyph_ser_pkg::DOT_W), .SHIFT_W(glyph_ser_pkg::SHIFT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ascii_in(ascii_in), .scan_row(scan_row),
    .cursor_here(cursor_here), .blink_en(blink_en), .load_stb(load_stb),
    .pixel_out(pixel_out), .busy(ser_busy), .dot_idx(ser_idx),
    .blink_phase(blink_phase), .blink_wrap(blink_wrap)
);

// File: tb/glyph_pixel_serializer_test.sv
module glyph_pixel_serializer_test;
    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ascii_in = '0;
    logic [2:0] scan_row = '0;
    logic       cursor_here = 1'b0;
    logic       blink_en = 1'b0;
    logic       load_stb = 1'b0;
    logic       pixel_out;

    int tests = 0;
    int fails = 0;
    int edges = 0;
    bit done = 1'b0;

    glyph_pixel_serializer #(.BLINK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .ascii_in(ascii_in), .scan_row(scan_row),
        .cursor_here(cursor_here), .blink_en(blink_en), .load_stb(load_stb),
        .pixel_out(pixel_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    function automatic int fold_code(input int a);
        if (a >= 64) return a % 32;
        return (a % 32) + 32;
    endfunction

    function automatic int font_row(input int c, input int r);
        if (r == 7 || c == 32) return 0;
        if (c == 0) begin
            case (r)
                0: return 14; 1: return 17; 2: return 23; 3: return 21;
                4: return 23; 5: return 16; default: return 15;
            endcase
        end
        return (c + 7 * r) % 32;
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // starts at a negedge, ends at the negedge after the eighth pixel
    task automatic shoot(input int a, input int r, input bit cur, input bit ben,
                         output logic [7:0] got, output int exp);
        int ph, c;
        ph = (edges / HALF) % 2;
        c  = fold_code(a);
        if (cur && ben && ph == 1) c = c ^ 32;
        exp = font_row(c, r) * 8;
        ascii_in = 7'(a); scan_row = 3'(r);
        cursor_here = cur; blink_en = ben; load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        got[7] = pixel_out;
        for (int i = 6; i >= 0; i--) begin
            @(negedge clk);
            got[i] = pixel_out;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int exp;
        // R1 during and after reset
        repeat (3) @(negedge clk);
        check(pixel_out == 1'b0, "R1 reset", pixel_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pixel_out == 1'b0, "R1 before load", pixel_out, 0);

        // sweep: R2 R3 R4 R5 R6
        for (int a = 0; a < 128; a++) begin
            for (int r = 0; r < 8; r++) begin
                int c;
                string tag;
                shoot(a, r, 1'b0, 1'b0, got, exp);
                c = fold_code(a);
                if (r == 7)                 tag = "R4 blank row";
                else if (c == 0 || c == 32) tag = "R5 at/space";
                else if (a >= 64 || a < 32) tag = "R3 fold";
                else                        tag = "R6 glyph";
                check(got == 8'(exp), $sformatf("%s a=%02h r=%0d R2", tag, a, r), got, exp);
            end
        end

        // R10 drain
        shoot(7'h41, 2, 1'b0, 1'b0, got, exp);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pixel_out == 1'b0, "R10 idle after pattern", pixel_out, 0);
        end

        // R7 R8 cursor blink over several half periods
        for (int k = 0; k < 12; k++) begin
            shoot(7'h20, 3, 1'b1, 1'b1, got, exp);
            check(got == 8'(exp), $sformatf("R7 R8 cursor space slot %0d", k), got, exp);
            shoot(7'h41, 1, 1'b1, 1'b1, got, exp);
            check(got == 8'(exp), $sformatf("R7 cursor letter slot %0d", k), got, exp);
        end

        // R9 blink disabled
        for (int k = 0; k < 8; k++) begin
            shoot(7'h20, 2, 1'b1, 1'b0, got, exp);
            check(got == 8'h00, "R9 cursor without blink", got, 0);
        end

        // R11 reload mid-pattern: 0x41 row2 -> code 1 -> 0x0F
        ascii_in = 7'h41; scan_row = 3'd2; cursor_here = 1'b0; blink_en = 1'b0;
        load_stb = 1'b1;
        @(negedge clk); load_stb = 1'b0; got[7] = pixel_out;
        @(negedge clk); got[6] = pixel_out;
        @(negedge clk); got[5] = pixel_out;
        check(got[7:5] == 3'b011, "R11 first pattern head", got[7:5], 3);
        ascii_in = 7'h40; scan_row = 3'd1; load_stb = 1'b1;
        @(negedge clk); load_stb = 1'b0; got[7] = pixel_out;
        for (int i = 6; i >= 0; i--) begin
            @(negedge clk);
            got[i] = pixel_out;
        end
        check(got == 8'h88, "R11 reloaded pattern", got, 8'h88);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule